// File: doc/BRIEF.md
# Fixed-Point Regression Perceptron for Track Momentum and Displacement

This block is a fully pipelined multilayer perceptron that turns a vector of 23 track features into two regression results. The first result is the signed inverse transverse momentum (charge over pT), estimated with no vertex constraint. The second is the transverse impact parameter. The network has three hidden layers of 30, 25 and 20 nodes, and a two-node linear output layer. Each node forms a weighted sum of its inputs and adds a bias. A per-channel scale and offset is applied to the raw inputs, and again to each hidden layer's sums before the rectifier.

All weights, biases and normalization constants are fixed when the block is built. Constant functions in the package generate them from a seed parameter, so the block holds no storage for coefficients. A candidate can enter on every clock. The result appears a fixed number of cycles later, qualified by a valid flag. There is no back-pressure, so a downstream consumer must take each result in the cycle it is presented.

Top module: `nn_regress_top`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 12 clock cycles. The result of the candidate presented with `in_valid` high at clock edge k is presented after edge k+11.
- R2: Each input feature c is first mapped to rnd(x·s0[c] + o0[c]), saturated. No rectifier is applied here, so negative normalized inputs pass on.
- R3: Each dense node computes (bias << 8) + Σ x·w at full precision, with no intermediate overflow. The sum is then rounded and saturated to 16 bits.
- R4: Each hidden layer applies its per-channel scale and offset to the dense result, then clamps any negative value to zero. No hidden activation is ever negative.
- R5: The two-node output layer is linear. Negative results reach `out_qpt` and `out_d0` unchanged.
- R6: Every rounded value is saturated: results above 32767 become 32767, and results below −32768 become −32768.
- R7: While `rst_n` is low, `out_valid`, `out_qpt` and `out_d0` are 0 after the next clock edge.
- R8: Candidates presented on consecutive cycles each produce their own independent result on consecutive cycles.
- R9: Data are signed two's complement with 8 fractional bits (Q7.8). The reduction from a wider sum adds 2^7, shifts arithmetically right by 8 and then saturates. `in_feat[16c+15:16c]` holds feature c. `out_qpt` is output node 0 and `out_d0` is output node 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks `in_feat` as a candidate this cycle |
| in_feat | input | 368 | 23 packed signed Q7.8 features, feature c at bits 16c+15:16c |
| out_valid | output | 1 | Marks the output pair as a result |
| out_qpt | output | 16 | Signed Q7.8 charge-over-pT estimate |
| out_d0 | output | 16 | Signed Q7.8 impact-parameter estimate |

## Verification
Some behaviours are checked on every cycle. The valid flag must trail the input flag by exactly twelve cycles. Reset must clear the output registers. No hidden-layer activation, in any of the three layers, may be negative. The numeric results can only be shown by the bench scenarios, which compare every output pair against an independent fixed-point model of the network. Those scenarios cover all-zero, full-scale positive, full-scale negative and alternating inputs that drive saturation, single active features, random candidates with gaps, and back-to-back bursts.

// File: rtl/nn_regress_pkg.sv
`timescale 1ns/1ps
// nn_regress_pkg
// Shared sizes, fixed-point types, the rounding/saturation helper and the
// constant functions that generate every coefficient of the network.
// Assumes seeds are non-negative; coefficients are small so they fit DATA_W.
package nn_regress_pkg;

    localparam int DATA_W    = 16;
    localparam int FRAC      = 8;
    localparam int ACC_W     = 2 * DATA_W + 16;
    localparam int N_FEAT    = 23;
    localparam int N_H1      = 30;
    localparam int N_H2      = 25;
    localparam int N_H3      = 20;
    localparam int N_OUT     = 2;
    localparam int DENSE_LAT = 2;
    localparam int NORM_LAT  = 1;
    localparam int PIPE_LAT  = NORM_LAT + 3 * (DENSE_LAT + NORM_LAT) + DENSE_LAT;

    typedef logic signed [DATA_W-1:0]   act_t;
    typedef logic signed [2*DATA_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    // Round half up at bit FRAC, shift down, clamp to the act_t range.
    function automatic act_t rnd_sat(input acc_t v);
        acc_t half;
        acc_t r;
        acc_t hi;
        acc_t lo;
        half           = '0;
        half[FRAC-1]   = 1'b1;
        hi             = acc_t'(act_t'({1'b0, {(DATA_W-1){1'b1}}}));
        lo             = acc_t'(act_t'({1'b1, {(DATA_W-1){1'b0}}}));
        r              = (v + half) >>> FRAC;
        if (r > hi)      return act_t'(hi[DATA_W-1:0]);
        else if (r < lo) return act_t'(lo[DATA_W-1:0]);
        else             return act_t'(r[DATA_W-1:0]);
    endfunction

    // Weight of input i into node o of dense layer lay (1..4).
    function automatic act_t dense_weight(input int seed, input int lay, input int o, input int i);
        int v;
        v = ((seed + lay * 7 + o * 13 + i * 5) % 41) - 20;
        return act_t'(v);
    endfunction

    // Bias of node o of dense layer lay, in Q7.8.
    function automatic act_t dense_bias(input int seed, input int lay, input int o);
        int v;
        v = (((seed + lay * 11 + o * 17) % 61) - 30) * 8;
        return act_t'(v);
    endfunction

    // Normalization scale of channel c in stage st (0 = inputs, 1..3 = hidden).
    function automatic act_t norm_scale(input int seed, input int st, input int c);
        int v;
        v = 256 + (((seed + st * 3 + c * 9) % 33) - 16) * 4;
        return act_t'(v);
    endfunction

    // Normalization offset of channel c in stage st, in Q7.8.
    function automatic act_t norm_offset(input int seed, input int st, input int c);
        int v;
        v = (((seed + st * 5 + c * 7) % 21) - 10) * 16;
        return act_t'(v);
    endfunction

endpackage

// File: rtl/nn_valid_pipe.sv
`timescale 1ns/1ps
// nn_valid_pipe
// Carries the candidate-valid flag alongside the data pipeline.
// Assumes DEPTH >= 1 and matches the data path register count.
module nn_valid_pipe #(
    parameter int DEPTH = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin,
    output logic vout
);

    logic [DEPTH-1:0] sh_q;

    // Shift the flag one stage per clock, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else if (DEPTH == 1) sh_q <= vin;
        else sh_q <= {sh_q[DEPTH-2:0], vin};
    end

    assign vout = sh_q[DEPTH-1];

endmodule

// File: rtl/nn_affine_stage.sv
`timescale 1ns/1ps
// nn_affine_stage
// Per-channel scale and offset, rounded and saturated, with an optional
// rectifier. One register stage. Coefficients come from the package.
// Assumes inputs and constants are Q7.8.
module nn_affine_stage
    import nn_regress_pkg::*;
#(
    parameter int N_CH     = 4,
    parameter int STAGE_ID = 0,
    parameter int SEED     = 0,
    parameter bit USE_RELU = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_CH-1:0][DATA_W-1:0]  x,
    output logic [N_CH-1:0][DATA_W-1:0]  y
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam act_t SC = norm_scale(SEED, STAGE_ID, c);
        localparam act_t OF = norm_offset(SEED, STAGE_ID, c);
        acc_t t_c;
        act_t r_c;
        act_t y_q;

        // Affine transform, then round, saturate and optionally rectify.
        always_comb begin
            t_c = acc_t'($signed(x[c])) * acc_t'(SC) + (acc_t'(OF) <<< FRAC);
            r_c = rnd_sat(t_c);
            if (USE_RELU && r_c[DATA_W-1]) r_c = '0;
        end

        // Register the channel result.
        always_ff @(posedge clk) begin
            if (!rst_n) y_q <= '0;
            else        y_q <= r_c;
        end

        assign y[c] = y_q;
    end

endmodule

// File: rtl/nn_dense_layer.sv
`timescale 1ns/1ps
// nn_dense_layer
// Fully parallel dense layer: one multiplier per weight registered in the
// first stage, the bias-seeded sum rounded and saturated in the second.
// Assumes ACC_W covers N_IN full-precision products without overflow.
module nn_dense_layer
    import nn_regress_pkg::*;
#(
    parameter int N_IN     = 4,
    parameter int N_NODE   = 4,
    parameter int LAYER_ID = 1,
    parameter int SEED     = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_IN-1:0][DATA_W-1:0]   x,
    output logic [N_NODE-1:0][DATA_W-1:0] y
);

    for (genvar o = 0; o < N_NODE; o++) begin : g_node
        localparam act_t BIAS = dense_bias(SEED, LAYER_ID, o);
        prod_t prod_q [N_IN];
        acc_t  sum_c;
        act_t  y_q;

        // Stage one: every input times its constant weight.
        always_ff @(posedge clk) begin
            for (int i = 0; i < N_IN; i++) begin
                if (!rst_n) prod_q[i] <= '0;
                else        prod_q[i] <= prod_t'($signed(x[i])) * prod_t'(dense_weight(SEED, LAYER_ID, o, i));
            end
        end

        // Full-precision sum seeded with the aligned bias.
        always_comb begin
            sum_c = acc_t'(BIAS) <<< FRAC;
            for (int i = 0; i < N_IN; i++) sum_c = sum_c + acc_t'(prod_q[i]);
        end

        // Stage two: round and saturate the node result.
        always_ff @(posedge clk) begin
            if (!rst_n) y_q <= '0;
            else        y_q <= rnd_sat(sum_c);
        end

        assign y[o] = y_q;
    end

endmodule

// File: rtl/nn_regress_top.sv
`timescale 1ns/1ps
// nn_regress_top
// 23-30-25-20-2 fixed-point regression perceptron. Input normalization,
// three dense+normalize+rectify hidden layers, linear two-node output.
// Accepts one candidate per clock, fixed latency PIPE_LAT, no back-pressure.
module nn_regress_top
    import nn_regress_pkg::*;
#(
    parameter int SEED = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [N_FEAT*DATA_W-1:0] in_feat,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        out_qpt,
    output logic [DATA_W-1:0]        out_d0
);

    logic [N_FEAT-1:0][DATA_W-1:0] feat_w;
    logic [N_FEAT-1:0][DATA_W-1:0] act0;
    logic [N_H1-1:0][DATA_W-1:0]   sum1;
    logic [N_H1-1:0][DATA_W-1:0]   act1;
    logic [N_H2-1:0][DATA_W-1:0]   sum2;
    logic [N_H2-1:0][DATA_W-1:0]   act2;
    logic [N_H3-1:0][DATA_W-1:0]   sum3;
    logic [N_H3-1:0][DATA_W-1:0]   act3;
    logic [N_OUT-1:0][DATA_W-1:0]  res;

    assign feat_w = in_feat;

    nn_affine_stage #(.N_CH(N_FEAT), .STAGE_ID(0), .SEED(SEED), .USE_RELU(1'b0)) norm0_i (
        .clk(clk), .rst_n(rst_n), .x(feat_w), .y(act0));

    nn_dense_layer #(.N_IN(N_FEAT), .N_NODE(N_H1), .LAYER_ID(1), .SEED(SEED)) dense1_i (
        .clk(clk), .rst_n(rst_n), .x(act0), .y(sum1));

    nn_affine_stage #(.N_CH(N_H1), .STAGE_ID(1), .SEED(SEED), .USE_RELU(1'b1)) norm1_i (
        .clk(clk), .rst_n(rst_n), .x(sum1), .y(act1));

    nn_dense_layer #(.N_IN(N_H1), .N_NODE(N_H2), .LAYER_ID(2), .SEED(SEED)) dense2_i (
        .clk(clk), .rst_n(rst_n), .x(act1), .y(sum2));

    nn_affine_stage #(.N_CH(N_H2), .STAGE_ID(2), .SEED(SEED), .USE_RELU(1'b1)) norm2_i (
        .clk(clk), .rst_n(rst_n), .x(sum2), .y(act2));

    nn_dense_layer #(.N_IN(N_H2), .N_NODE(N_H3), .LAYER_ID(3), .SEED(SEED)) dense3_i (
        .clk(clk), .rst_n(rst_n), .x(act2), .y(sum3));

    nn_affine_stage #(.N_CH(N_H3), .STAGE_ID(3), .SEED(SEED), .USE_RELU(1'b1)) norm3_i (
        .clk(clk), .rst_n(rst_n), .x(sum3), .y(act3));

    nn_dense_layer #(.N_IN(N_H3), .N_NODE(N_OUT), .LAYER_ID(4), .SEED(SEED)) dense_out_i (
        .clk(clk), .rst_n(rst_n), .x(act3), .y(res));

    nn_valid_pipe #(.DEPTH(PIPE_LAT)) vpipe_i (
        .clk(clk), .rst_n(rst_n), .vin(in_valid), .vout(out_valid));

    assign out_qpt = res[0];
    assign out_d0  = res[1];

endmodule

// File: rtl/nn_regress_chk.sv
`timescale 1ns/1ps
// nn_regress_chk
// Assertion checker bound to nn_regress_top: valid timing against an
// independent flag history, reset clearing, and non-negative hidden layers.
module nn_regress_chk
    import nn_regress_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_valid,
    input logic                         out_valid,
    input logic [DATA_W-1:0]            out_qpt,
    input logic [DATA_W-1:0]            out_d0,
    input logic [N_H1-1:0][DATA_W-1:0]  h1,
    input logic [N_H2-1:0][DATA_W-1:0]  h2,
    input logic [N_H3-1:0][DATA_W-1:0]  h3
);

    localparam int CW = $clog2(PIPE_LAT + 1);

    logic [PIPE_LAT-1:0] hist_q;
    logic [CW-1:0]       age_q;
    logic                warm;
    logic [N_H1-1:0]     sgn1;
    logic [N_H2-1:0]     sgn2;
    logic [N_H3-1:0]     sgn3;

    // Record the input flag history and the cycles since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            age_q  <= '0;
        end else begin
            hist_q <= {hist_q[PIPE_LAT-2:0], in_valid};
            if (age_q != CW'(PIPE_LAT)) age_q <= age_q + 1'b1;
        end
    end

    assign warm = (age_q == CW'(PIPE_LAT));

    // Gather the sign bits of every hidden activation.
    always_comb begin
        for (int c = 0; c < N_H1; c++) sgn1[c] = h1[c][DATA_W-1];
        for (int c = 0; c < N_H2; c++) sgn2[c] = h2[c][DATA_W-1];
        for (int c = 0; c < N_H3; c++) sgn3[c] = h3[c][DATA_W-1];
    end

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == hist_q[PIPE_LAT-1]));

    // R1
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !warm |-> !out_valid);

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_qpt == '0 && out_d0 == '0));

    // R4
    relu_h1_chk: assert property (@(posedge clk) disable iff (!rst_n) sgn1 == '0);

    // R4
    relu_h2_chk: assert property (@(posedge clk) disable iff (!rst_n) sgn2 == '0);

    // R4
    relu_h3_chk: assert property (@(posedge clk) disable iff (!rst_n) sgn3 == '0);

endmodule

bind nn_regress_top nn_regress_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_qpt(out_qpt), .out_d0(out_d0), .h1(act1), .h2(act2), .h3(act3));

// File: tb/nn_regress_top_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random candidates, compared against a
// fixed-point reference model of the network written from the requirements.
module nn_regress_top_tb_top;
    import nn_regress_pkg::*;

    localparam int LAT = 12;
    localparam int NIT = 900;
    localparam int NF  = 23;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 in_valid;
    logic [NF*16-1:0]     in_feat;
    logic                 out_valid;
    logic [15:0]          out_qpt;
    logic [15:0]          out_d0;

    int    n_chk = 0;
    int    n_fail = 0;
    int    it = 0;
    bit    done = 1'b0;
    bit    exp_v [NIT];
    int    exp_q [NIT];
    int    exp_d [NIT];
    string exp_tag [NIT];

    always #4 clk = ~clk;

    nn_regress_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_feat(in_feat),
        .out_valid(out_valid), .out_qpt(out_qpt), .out_d0(out_d0));

    task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, expv, it);
        end
    endtask

    // Round half up, shift by 8, saturate to 16 bits (R9, R6).
    function automatic int bsat(input longint v);
        longint r;
        r = (v + 128) >>> 8;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    function automatic int nrm(input int x, input int st, input int c, input bit relu);
        int r;
        r = bsat(longint'(x) * longint'(norm_scale(0, st, c)) + (longint'(norm_offset(0, st, c)) <<< 8));
        if (relu && r < 0) r = 0;
        return r;
    endfunction

    function automatic void dense(input int x[32], input int nin, input int nout, input int lay, output int y[32]);
        for (int o = 0; o < 32; o++) y[o] = 0;
        for (int o = 0; o < nout; o++) begin
            longint acc;
            acc = longint'(dense_bias(0, lay, o)) <<< 8;
            for (int i = 0; i < nin; i++) acc += longint'(x[i]) * longint'(dense_weight(0, lay, o, i));
            y[o] = bsat(acc);
        end
    endfunction

    function automatic void model(input int f[NF], output int q, output int d);
        int a[32];
        int b[32];
        for (int c = 0; c < 32; c++) a[c] = 0;
        for (int c = 0; c < NF; c++) a[c] = nrm(f[c], 0, c, 1'b0);
        dense(a, NF, 30, 1, b);
        for (int c = 0; c < 30; c++) a[c] = nrm(b[c], 1, c, 1'b1);
        dense(a, 30, 25, 2, b);
        for (int c = 0; c < 32; c++) a[c] = (c < 25) ? nrm(b[c], 2, c, 1'b1) : 0;
        dense(a, 25, 20, 3, b);
        for (int c = 0; c < 32; c++) a[c] = (c < 20) ? nrm(b[c], 3, c, 1'b1) : 0;
        dense(a, 20, 2, 4, b);
        q = b[0];
        d = b[1];
    endfunction

    // One cycle: check the result due now, then present the next candidate.
    task automatic cycle(input bit v, input int f[NF], input string tag);
        int  k;
        bit  ev;
        int  q;
        int  d;
        @(negedge clk);
        k  = it - LAT;
        ev = (k >= 0) ? exp_v[k] : 1'b0;
        check(out_valid == ev, "R1", "out_valid", int'(out_valid), int'(ev));
        if (ev) begin
            check($signed(out_qpt) == exp_q[k], exp_tag[k], "out_qpt", int'($signed(out_qpt)), exp_q[k]);
            check($signed(out_d0) == exp_d[k], exp_tag[k], "out_d0", int'($signed(out_d0)), exp_d[k]);
        end
        in_valid = v;
        for (int c = 0; c < NF; c++) in_feat[c*16 +: 16] = 16'(f[c]);
        model(f, q, d);
        if (it < NIT) begin
            exp_v[it]   = v;
            exp_q[it]   = q;
            exp_d[it]   = d;
            exp_tag[it] = tag;
            it++;
        end
    endtask

    function automatic int rnd_val(input int mode);
        case (mode)
            0:       return $urandom_range(0, 65535) - 32768;
            1:       return $urandom_range(0, 2047) - 1024;
            default: return $urandom_range(0, 255) - 128;
        endcase
    endfunction

    initial begin
        int f[NF];
        void'($urandom(32'h5eed_0123));
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_feat  = '1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R7: reset clears the valid flag and both outputs.
        check(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
        check(out_qpt == 16'd0, "R7", "out_qpt in reset", int'($signed(out_qpt)), 0);
        check(out_d0 == 16'd0, "R7", "out_d0 in reset", int'($signed(out_d0)), 0);
        in_valid = 1'b0;
        in_feat  = '0;
        rst_n    = 1'b1;

        // R3: zero features expose biases and offsets alone.
        for (int c = 0; c < NF; c++) f[c] = 0;
        cycle(1'b1, f, "R3");
        // R6: full-scale inputs of each sign drive saturation.
        for (int c = 0; c < NF; c++) f[c] = 32767;
        cycle(1'b1, f, "R6");
        for (int c = 0; c < NF; c++) f[c] = -32768;
        cycle(1'b1, f, "R6");
        for (int c = 0; c < NF; c++) f[c] = (c % 2) ? 32767 : -32768;
        cycle(1'b1, f, "R6");
        // R2: one active feature at a time, negative values pass normalization.
        for (int s = 0; s < NF; s++) begin
            for (int c = 0; c < NF; c++) f[c] = (c == s) ? ((s % 2) ? -4000 : 4000) : 0;
            cycle(1'b1, f, "R2");
        end
        // R5 R9: random candidates with gaps, mixed magnitudes.
        for (int n = 0; n < 400; n++) begin
            int m;
            m = $urandom_range(0, 2);
            for (int c = 0; c < NF; c++) f[c] = rnd_val(m);
            cycle(($urandom_range(0, 9) < 7), f, (m == 0) ? "R6" : "R5 R9");
        end
        // R8: back-to-back burst of independent candidates.
        for (int n = 0; n < 200; n++) begin
            for (int c = 0; c < NF; c++) f[c] = rnd_val(n % 3);
            cycle(1'b1, f, "R8");
        end
        // R1: idle gap then a lone candidate, then drain.
        for (int c = 0; c < NF; c++) f[c] = 0;
        for (int n = 0; n < 20; n++) cycle(1'b0, f, "R1");
        for (int c = 0; c < NF; c++) f[c] = 1000 - 90 * c;
        cycle(1'b1, f, "R1");
        for (int c = 0; c < NF; c++) f[c] = 0;
        for (int n = 0; n < LAT + 4; n++) cycle(1'b0, f, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", it, NIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule